// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and the internals of a flash-style memory. Each host write carries a command byte in the low byte of the data word, or an operand on the second write of a two-write sequence. The block tracks which view a read returns: array contents, status, identifier and lock configuration, or query data. It runs the two-write sequences for program, protection-register program, block erase and lock actions. When a sequence completes it issues one-cycle requests to a separate write engine and to a lock manager, together with the latched operand address and data.

The block also owns the 8-bit status register. The ready bit and the two suspend bits follow the engine's level signals. The four error bits are sticky: once set by engine error flags or by a malformed sequence, they stay set until the clear command or a reset. Which commands are legal depends on the engine context: idle, busy, erase suspended or program suspended. When the engine reports both suspends, the program-suspend context wins. A command that is not legal in the current context is ignored.

Top module: `flashCmdDecoder`

## Requirements
- R1: After reset, `rdSel` is 0 (array view), `statusWord` reads 0x0080, and no request output is high.
- R2: With the engine idle, command bytes 0xFF, 0x70, 0x90 and 0x98 set `rdSel` to 0 (array), 1 (status), 2 (configuration) and 3 (query), respectively. The new value shows in the cycle after the write.
- R3: Writing 0x40 or 0x10 and then any word raises `startProg` for one cycle. Writing 0xC0 and then any word raises `startProtProg` instead. In both cases `opAddr`/`opData` take the second write's address and data, and `rdSel` becomes 1.
- R4: Writing 0x20 and then 0xD0 raises `startErase` for one cycle, latches the confirm write's address in `opAddr`, and sets `rdSel` to 1.
- R5: Writing 0x20 and then any byte other than 0xD0 starts no erase. It sets status bits 4 and 5 and sets `rdSel` to 1.
- R6: Writing 0x60 and then 0x01, 0xD0 or 0x2F raises `lockReq` for one cycle, with `lockAct` equal to 0 (lock), 1 (unlock) or 2 (lock-down) and `opAddr` latched. Any other second byte raises no `lockReq`, sets status bits 4 and 5, and leaves `rdSel` unchanged.
- R7: Each pulse on `engErr` bit 0, 1, 2 or 3 sets status bit 1, 3, 4 or 5, respectively. These bits stay set until 0x50 is written while the engine is idle, or until reset. Status bit 7 follows the inverse of `engBusy`, bit 6 follows `engErsSusp`, and bit 2 follows `engPgmSusp`.
- R8: While the engine is busy, only three commands act: 0x70 (status view), 0xB0 (`suspendReq`) and 0xD0 (`resumeReq`). Every other command is ignored, and no start or lock request is issued.
- R9: While erase is suspended, the decoder accepts the four view commands, the program sequence, the 0x60 lock sequences, and 0xD0, which raises `resumeReq` and sets `rdSel` to 1. It ignores 0x20, 0xC0, 0x50 and 0xB0.
- R10: While program is suspended, the decoder accepts the four view commands and 0xD0 (resume, `rdSel` 1). It ignores 0x40, 0x60, 0x50 and all other bytes.
- R11: Bytes outside the command set are ignored and leave `rdSel` unchanged. This includes 0xB0 and 0xD0 while the engine is idle.
- R12: `statusWord` shows 0x00 in its upper byte and the status register in its low byte. The value is captured in the cycle where `rdStb` rises and is held while `rdStb` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | One-cycle bus write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data; command in bits 7:0 |
| rdStb | input | 1 | Read cycle active |
| engBusy | input | 1 | Write engine running |
| engErsSusp | input | 1 | Erase suspended |
| engPgmSusp | input | 1 | Program suspended |
| engErr | input | 4 | Error flag pulses: lock, voltage, program, erase |
| startProg | output | 1 | Array program request |
| startErase | output | 1 | Block erase request |
| startProtProg | output | 1 | Protection-register program request |
| suspendReq | output | 1 | Suspend request |
| resumeReq | output | 1 | Resume request |
| lockReq | output | 1 | Lock manager request |
| lockAct | output | 2 | Lock action: 0 lock, 1 unlock, 2 lock-down |
| opAddr | output | ADDR_W | Latched operand address |
| opData | output | DATA_W | Latched operand data |
| rdSel | output | 2 | Read view select |
| statusWord | output | DATA_W | Captured status for reads |

## Verification
Four properties are checked on every cycle:
- At most one request pulse is high at a time.
- A busy engine never gets a start or lock request.
- A malformed erase sequence always ends in the status view without starting an erase.
- An error bit never falls except after a clear, and a captured status value never moves mid-read.

The directed scenarios are needed for the rest. They cover the per-context acceptance tables, the operand latching, the exact lock action codes, and the sticky bits surviving other commands until a clear or a reset.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_PGM_SETUP   = 8'h40;
  localparam logic [7:0] CMD_PGM_ALT     = 8'h10;
  localparam logic [7:0] CMD_ERS_SETUP   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_READ_CONFIG = 8'h90;
  localparam logic [7:0] CMD_READ_QUERY  = 8'h98;
  localparam logic [7:0] CMD_CFG_SETUP   = 8'h60;
  localparam logic [7:0] CMD_LOCK        = 8'h01;
  localparam logic [7:0] CMD_LOCKDOWN    = 8'h2F;
  localparam logic [7:0] CMD_PROT_SETUP  = 8'hC0;

  localparam logic [1:0] LACT_LOCK     = 2'd0;
  localparam logic [1:0] LACT_UNLOCK   = 2'd1;
  localparam logic [1:0] LACT_LOCKDOWN = 2'd2;

  // status bit positions
  localparam int SR_READY    = 7;
  localparam int SR_ERS_SUSP = 6;
  localparam int SR_ERS_ERR  = 5;
  localparam int SR_PGM_ERR  = 4;
  localparam int SR_VOLT_ERR = 3;
  localparam int SR_PGM_SUSP = 2;
  localparam int SR_LOCK_ERR = 1;
  localparam logic [7:0] SR_STICKY_MASK = 8'h3A;
  localparam logic [7:0] SR_RESET_VAL   = 8'h80;

  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_CONFIG, RD_QUERY} rdMode_e;
  typedef enum logic [2:0] {SEQ_NONE, SEQ_PGM, SEQ_PROT, SEQ_ERS, SEQ_CFG} seq_e;
  typedef enum logic [1:0] {CTX_IDLE, CTX_BUSY, CTX_ERS_SUSP, CTX_PGM_SUSP} ctx_e;

  typedef struct packed {
    logic latchOp;
    logic seqErr;
    logic clrSticky;
  } dpStrobe_t;
endpackage

// File: rtl/fcdCmdCtrl.sv
module fcdCmdCtrl
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrCmd,
  input  logic       engBusy,
  input  logic       engErsSusp,
  input  logic       engPgmSusp,
  output logic       startProg,
  output logic       startErase,
  output logic       startProtProg,
  output logic       suspendReq,
  output logic       resumeReq,
  output logic       lockReq,
  output logic [1:0] lockAct,
  output rdMode_e    rdMode,
  output dpStrobe_t  strb
);
  seq_e    seqQ, seqN;
  rdMode_e modeN;
  ctx_e    ctx;
  logic    goProg, goErs, goProt, goSusp, goRes, goLock;
  logic [1:0] lockActN;

  always_comb begin
    if (engPgmSusp)      ctx = CTX_PGM_SUSP;
    else if (engErsSusp) ctx = CTX_ERS_SUSP;
    else if (engBusy)    ctx = CTX_BUSY;
    else                 ctx = CTX_IDLE;
  end

  always_comb begin
    seqN = seqQ;
    modeN = rdMode;
    goProg = 1'b0; goErs = 1'b0; goProt = 1'b0;
    goSusp = 1'b0; goRes = 1'b0; goLock = 1'b0;
    lockActN = lockAct;
    strb = '0;
    if (wrEn) begin
      seqN = SEQ_NONE;
      case (seqQ)
        SEQ_PGM, SEQ_PROT: begin
          goProg = (seqQ == SEQ_PGM);
          goProt = (seqQ == SEQ_PROT);
          strb.latchOp = 1'b1;
          modeN = RD_STATUS;
        end
        SEQ_ERS: begin
          modeN = RD_STATUS;
          if (wrCmd == CMD_CONFIRM) begin
            goErs = 1'b1;
            strb.latchOp = 1'b1;
          end else begin
            strb.seqErr = 1'b1;
          end
        end
        SEQ_CFG: begin
          case (wrCmd)
            CMD_LOCK:     begin goLock = 1'b1; lockActN = LACT_LOCK;     strb.latchOp = 1'b1; end
            CMD_CONFIRM:  begin goLock = 1'b1; lockActN = LACT_UNLOCK;   strb.latchOp = 1'b1; end
            CMD_LOCKDOWN: begin goLock = 1'b1; lockActN = LACT_LOCKDOWN; strb.latchOp = 1'b1; end
            default:      strb.seqErr = 1'b1;
          endcase
        end
        default: begin
          case (wrCmd)
            CMD_READ_ARRAY:  if (ctx != CTX_BUSY) modeN = RD_ARRAY;
            CMD_READ_STATUS: modeN = RD_STATUS;
            CMD_READ_CONFIG: if (ctx != CTX_BUSY) modeN = RD_CONFIG;
            CMD_READ_QUERY:  if (ctx != CTX_BUSY) modeN = RD_QUERY;
            CMD_PGM_SETUP, CMD_PGM_ALT:
              if (ctx == CTX_IDLE || ctx == CTX_ERS_SUSP) seqN = SEQ_PGM;
            CMD_PROT_SETUP:  if (ctx == CTX_IDLE) seqN = SEQ_PROT;
            CMD_ERS_SETUP:   if (ctx == CTX_IDLE) seqN = SEQ_ERS;
            CMD_CFG_SETUP:
              if (ctx == CTX_IDLE || ctx == CTX_ERS_SUSP) seqN = SEQ_CFG;
            CMD_CLR_STATUS:  if (ctx == CTX_IDLE) strb.clrSticky = 1'b1;
            CMD_SUSPEND:     if (ctx == CTX_BUSY) goSusp = 1'b1;
            CMD_CONFIRM: begin
              if (ctx != CTX_IDLE) begin
                goRes = 1'b1;
                modeN = RD_STATUS;
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ <= SEQ_NONE;
      rdMode <= RD_ARRAY;
      startProg <= 1'b0; startErase <= 1'b0; startProtProg <= 1'b0;
      suspendReq <= 1'b0; resumeReq <= 1'b0; lockReq <= 1'b0;
      lockAct <= LACT_LOCK;
    end else begin
      seqQ <= seqN;
      rdMode <= modeN;
      startProg <= goProg; startErase <= goErs; startProtProg <= goProt;
      suspendReq <= goSusp; resumeReq <= goRes; lockReq <= goLock;
      lockAct <= lockActN;
    end
  end

  // R1: the read view is array right after reset
  assert_reset_view_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> rdMode == RD_ARRAY);

  assert_single_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startProg, startErase, startProtProg, suspendReq, resumeReq, lockReq}));

  assert_start_shows_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startProg || startErase || startProtProg) |-> rdMode == RD_STATUS);

  assert_erase_bad_confirm_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && seqQ == SEQ_ERS && wrCmd != CMD_CONFIRM) |=> (rdMode == RD_STATUS && !startErase));

  assert_busy_no_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && engBusy && !engErsSusp && !engPgmSusp && seqQ == SEQ_NONE)
      |=> !(startProg || startErase || startProtProg || lockReq));
endmodule

// File: rtl/fcdStatusPath.sv
module fcdStatusPath
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStb,
  input  logic              engBusy,
  input  logic              engErsSusp,
  input  logic              engPgmSusp,
  input  logic [3:0]        engErr,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [DATA_W-1:0] statusWord
);
  localparam int UPPER_W = DATA_W - 8;

  logic [7:0] srQ, srN, setMask, srHold;
  logic       rdStbQ;

  always_comb begin
    setMask = '0;
    setMask[SR_LOCK_ERR] = engErr[0];
    setMask[SR_VOLT_ERR] = engErr[1];
    setMask[SR_PGM_ERR]  = engErr[2] | strb.seqErr;
    setMask[SR_ERS_ERR]  = engErr[3] | strb.seqErr;
  end

  always_comb begin
    srN = srQ & SR_STICKY_MASK;
    if (strb.clrSticky) srN = '0;
    srN = srN | setMask;
    srN[SR_READY]    = !engBusy;
    srN[SR_ERS_SUSP] = engErsSusp;
    srN[SR_PGM_SUSP] = engPgmSusp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srQ <= SR_RESET_VAL;
      srHold <= SR_RESET_VAL;
      rdStbQ <= 1'b0;
      opAddr <= '0;
      opData <= '0;
    end else begin
      srQ <= srN;
      rdStbQ <= rdStb;
      if (rdStb && !rdStbQ) srHold <= srQ;
      if (strb.latchOp) begin
        opAddr <= wrAddr;
        opData <= wrData;
      end
    end
  end

  generate
    if (UPPER_W > 0) begin : g_wide
      assign statusWord = {{UPPER_W{1'b0}}, srHold};
    end else begin : g_byte
      assign statusWord = srHold;
    end
  endgenerate

  assert_sticky_only_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    (($past(srQ & SR_STICKY_MASK) & ~(srQ & SR_STICKY_MASK)) != 8'h00) |-> $past(strb.clrSticky));

  assert_capture_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdStb && rdStbQ) |-> $stable(statusWord));
endmodule

// File: rtl/flashCmdDecoder.sv
module flashCmdDecoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStb,
  input  logic              engBusy,
  input  logic              engErsSusp,
  input  logic              engPgmSusp,
  input  logic [3:0]        engErr,
  output logic              startProg,
  output logic              startErase,
  output logic              startProtProg,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic              lockReq,
  output logic [1:0]        lockAct,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [1:0]        rdSel,
  output logic [DATA_W-1:0] statusWord
);
  dpStrobe_t strb;
  rdMode_e   rdMode;

  fcdCmdCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCmd(wrData[7:0]),
    .engBusy(engBusy), .engErsSusp(engErsSusp), .engPgmSusp(engPgmSusp),
    .startProg(startProg), .startErase(startErase), .startProtProg(startProtProg),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .lockReq(lockReq),
    .lockAct(lockAct), .rdMode(rdMode), .strb(strb)
  );

  fcdStatusPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) path_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdStb(rdStb), .engBusy(engBusy), .engErsSusp(engErsSusp),
    .engPgmSusp(engPgmSusp), .engErr(engErr),
    .opAddr(opAddr), .opData(opData), .statusWord(statusWord)
  );

  assign rdSel = rdMode;
endmodule

// File: tb/flashCmdDecoder_tb.sv
module flashCmdDecoder_tb_top;
  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic rdStb = 1'b0;
  logic engBusy = 1'b0, engErsSusp = 1'b0, engPgmSusp = 1'b0;
  logic [3:0] engErr = '0;
  logic startProg, startErase, startProtProg, suspendReq, resumeReq, lockReq;
  logic [1:0] lockAct, rdSel;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] opData, statusWord;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  flashCmdDecoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdStb(rdStb), .engBusy(engBusy), .engErsSusp(engErsSusp), .engPgmSusp(engPgmSusp),
    .engErr(engErr), .startProg(startProg), .startErase(startErase),
    .startProtProg(startProtProg), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .lockReq(lockReq), .lockAct(lockAct), .opAddr(opAddr), .opData(opData),
    .rdSel(rdSel), .statusWord(statusWord)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // outputs of a write are valid at the negedge this task returns on
  task automatic wr(input logic [15:0] d, input logic [ADDR_W-1:0] a = '0);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; wrAddr = a;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readStatus(output logic [15:0] v);
    @(negedge clk);
    rdStb = 1'b1;
    @(negedge clk);
    v = statusWord;
    rdStb = 1'b0;
  endtask

  task automatic pulseErr(input logic [3:0] e);
    @(negedge clk);
    engErr = e;
    @(negedge clk);
    engErr = '0;
  endtask

  function automatic logic [5:0] reqs();
    return {startProg, startErase, startProtProg, suspendReq, resumeReq, lockReq};
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] s;
    doReset();
    chk("R1 rdSel", rdSel, 0);
    chk("R1 requests", reqs(), 0);
    readStatus(s);
    chk("R1 status", s, 16'h0080);
  endtask

  task automatic t_modes();
    wr(16'h0090); chk("R2 config view", rdSel, 2);
    wr(16'h0098); chk("R2 query view", rdSel, 3);
    wr(16'h0070); chk("R2 status view", rdSel, 1);
    wr(16'h00FF); chk("R2 array view", rdSel, 0);
  endtask

  task automatic t_unknown();
    wr(16'h0090);
    wr(16'h0033); chk("R11 unknown keeps view", rdSel, 2);
    wr(16'h00B0); chk("R11 idle suspend ignored", suspendReq, 0);
    wr(16'h00D0); chk("R11 idle resume ignored", resumeReq, 0);
    chk("R11 view kept", rdSel, 2);
    wr(16'h00FF);
  endtask

  task automatic t_program();
    wr(16'h0040); chk("R3 no start on setup", startProg, 0);
    wr(16'h1234, 21'h01234);
    chk("R3 startProg", startProg, 1);
    chk("R3 opData", opData, 16'h1234);
    chk("R3 opAddr", opAddr, 21'h01234);
    chk("R3 status view", rdSel, 1);
    wr(16'h00FF);
    wr(16'h0010); wr(16'hBEEF, 21'h00005);
    chk("R3 alt setup start", startProg, 1);
    chk("R3 alt opData", opData, 16'hBEEF);
    wr(16'h00FF);
    wr(16'h00C0); wr(16'h00AA, 21'h00081);
    chk("R3 prot start", {startProtProg, startProg}, 2'b10);
    chk("R3 prot opAddr", opAddr, 21'h00081);
    wr(16'h00FF);
  endtask

  task automatic t_erase();
    logic [15:0] s;
    wr(16'h0020, 21'h1F000); wr(16'h00D0, 21'h1F000);
    chk("R4 startErase", startErase, 1);
    chk("R4 opAddr", opAddr, 21'h1F000);
    chk("R4 status view", rdSel, 1);
    readStatus(s); chk("R4 no error", s, 16'h0080);
    wr(16'h00FF);
    wr(16'h0020); wr(16'h00FF);
    chk("R5 no erase", startErase, 0);
    chk("R5 status view", rdSel, 1);
    readStatus(s); chk("R5 bits 4 and 5", s, 16'h00B0);
    wr(16'h0050);
    readStatus(s); chk("R7 cleared after sequence error", s, 16'h0080);
    wr(16'h00FF);
  endtask

  task automatic t_cfg();
    logic [15:0] s;
    wr(16'h0090);
    wr(16'h0060); wr(16'h0001, 21'h00003);
    chk("R6 lock", {lockReq, lockAct}, 3'b100);
    chk("R6 opAddr", opAddr, 21'h00003);
    wr(16'h0060); wr(16'h00D0);
    chk("R6 unlock", {lockReq, lockAct}, 3'b101);
    wr(16'h0060); wr(16'h002F);
    chk("R6 lock-down", {lockReq, lockAct}, 3'b110);
    chk("R6 view unchanged", rdSel, 2);
    wr(16'h0060); wr(16'h0055);
    chk("R6 bad byte no request", lockReq, 0);
    chk("R6 bad byte view kept", rdSel, 2);
    readStatus(s); chk("R6 bad byte bits 4 and 5", s, 16'h00B0);
    wr(16'h0050); wr(16'h00FF);
  endtask

  task automatic t_sticky();
    logic [15:0] s;
    pulseErr(4'b1111);
    readStatus(s); chk("R7 all error bits", s, 16'h00BA);
    wr(16'h00FF); wr(16'h0070);
    readStatus(s); chk("R7 errors survive commands", s, 16'h00BA);
    wr(16'h0050);
    readStatus(s); chk("R7 clear", s, 16'h0080);
    pulseErr(4'b0100);
    readStatus(s); chk("R7 program error only", s, 16'h0090);
    doReset();
    readStatus(s); chk("R1 reset clears errors", s, 16'h0080);
    chk("R1 reset view", rdSel, 0);
  endtask

  task automatic t_busy();
    logic [15:0] s;
    wr(16'h0040); wr(16'h1111);
    @(negedge clk); engBusy = 1'b1;
    readStatus(s); chk("R7 ready bit low", s, 16'h0000);
    wr(16'h00FF); chk("R8 array ignored", rdSel, 1);
    wr(16'h0090); chk("R8 config ignored", rdSel, 1);
    wr(16'h0040); wr(16'h0055);
    chk("R8 no program", startProg, 0);
    wr(16'h00B0); chk("R8 suspend", suspendReq, 1);
    wr(16'h00D0); chk("R8 resume", resumeReq, 1);
    @(negedge clk); engBusy = 1'b0;
    wr(16'h00FF);
  endtask

  task automatic t_ers_susp();
    logic [15:0] s;
    @(negedge clk); engErsSusp = 1'b1;
    readStatus(s); chk("R7 erase suspend bit", s, 16'h00C0);
    wr(16'h0090); chk("R9 config view", rdSel, 2);
    pulseErr(4'b0001);
    wr(16'h0050);
    readStatus(s); chk("R9 clear ignored", s, 16'h00C2);
    wr(16'h0020); wr(16'h0044);
    chk("R9 erase setup ignored", startErase, 0);
    chk("R9 view kept", rdSel, 2);
    wr(16'h00C0); wr(16'h0066);
    chk("R9 prot setup ignored", startProtProg, 0);
    wr(16'h00B0); chk("R9 suspend ignored", suspendReq, 0);
    wr(16'h0040); wr(16'h0ABC, 21'h00007);
    chk("R9 program", startProg, 1);
    chk("R9 program data", opData, 16'h0ABC);
    wr(16'h0060); wr(16'h002F);
    chk("R9 lock-down", {lockReq, lockAct}, 3'b110);
    wr(16'h00D0);
    chk("R9 resume", resumeReq, 1);
    chk("R9 resume view", rdSel, 1);
    @(negedge clk); engErsSusp = 1'b0;
    wr(16'h0050);
    readStatus(s); chk("R7 idle clear", s, 16'h0080);
    wr(16'h00FF);
  endtask

  task automatic t_pgm_susp();
    logic [15:0] s;
    @(negedge clk); engPgmSusp = 1'b1;
    readStatus(s); chk("R7 program suspend bit", s, 16'h0084);
    wr(16'h0098); chk("R10 query view", rdSel, 3);
    wr(16'h0040); wr(16'h0099);
    chk("R10 program ignored", startProg, 0);
    chk("R10 view kept", rdSel, 3);
    wr(16'h0060); wr(16'h0001);
    chk("R10 lock ignored", lockReq, 0);
    pulseErr(4'b0100);
    wr(16'h0050);
    readStatus(s); chk("R10 clear ignored", s, 16'h0094);
    wr(16'h00D0);
    chk("R10 resume", resumeReq, 1);
    chk("R10 resume view", rdSel, 1);
    @(negedge clk); engPgmSusp = 1'b0;
    wr(16'h0050); wr(16'h00FF);
  endtask

  task automatic t_capture();
    @(negedge clk); rdStb = 1'b1;
    @(negedge clk);
    chk("R12 captured", statusWord, 16'h0080);
    pulseErr(4'b0100);
    @(negedge clk);
    chk("R12 held during read", statusWord, 16'h0080);
    rdStb = 1'b0;
    @(negedge clk); rdStb = 1'b1;
    @(negedge clk);
    chk("R12 new read", statusWord, 16'h0090);
    rdStb = 1'b0;
    wr(16'h0050);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    t_reset();
    t_modes();
    t_unknown();
    t_program();
    t_erase();
    t_cfg();
    t_sticky();
    t_busy();
    t_ers_susp();
    t_pgm_susp();
    t_capture();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule